// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog with a small write-only register interface. Software loads a timeout value, an optional service window and a configuration word. Each of these registers takes its first write after reset and ignores every later one. The counter either starts running straight out of reset, when a build parameter says so, or starts when software sets the enable bit. It steps down on an active tick. The tick is either every clock cycle or a pulse on a clock-enable input that comes from a slow internal oscillator. The counter can be frozen while a debug-halt input is high.

Software keeps the watchdog quiet by servicing it: two key words written in a fixed order to the service register. A service reloads the counter. A wrong key, a key out of order, or a service made too early while windowed mode is on counts as a fault. The counter reaching zero is also a fault. The configured response to a fault is one of three: a sticky reset request, an interrupt that also reloads the counter, or an interrupt first and a reset request if a second fault arrives before software clears the interrupt.

Top module: `wdt_window_top`

## Requirements
- R1: After reset `irq_o` and `rst_req_o` are 0 and `count_o` equals `RST_TIMEOUT`. With `EN_AT_RESET`=1 the counter decrements from the first clock after reset without any register write.
- R2: Configuration bit 0 (address 0) enables the watchdog, and once set it stays set. While disabled, `count_o` holds the timeout register value, writes to the service address have no effect, and neither output rises.
- R3: While enabled, the count falls by exactly one per active tick. Configuration bit 5 selects the tick: 0 means every clock cycle, 1 means only cycles with `osc_tick` high.
- R4: The configuration (address 0), timeout (address 1) and window (address 2) registers each accept only their first write after reset. Later writes to them change nothing.
- R5: A valid service is a write of 0xA602 to address 3 followed by a write of 0xB480 to address 3. It reloads the count with the timeout value on the edge of the second write.
- R6: Any other value written to address 3, or 0xB480 without a preceding 0xA602, or 0xA602 twice in a row, is a fault.
- R7: With configuration bit 1 set (windowed mode), a completed service while the count is above the window register is a fault. A service while the count is at or below the window value is valid.
- R8: An active tick with the count at zero is a timeout fault, unless a valid service completes on the same edge.
- R9: Configuration bits [3:2] select the response: 00 or 11 sets `rst_req_o`, which stays high until reset and stops the counter. 01 sets `irq_o`, reloads the count and never raises `rst_req_o`.
- R10: Response 10 sets `irq_o` and reloads the count on a fault. A fault while `irq_o` is already high sets `rst_req_o`. Writing 1 in bit 0 to address 4 clears `irq_o`.
- R11: With configuration bit 4 set, the count holds while `dbg_halt` is high. With bit 4 clear, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 configuration, 1 timeout, 2 window, 3 service key, 4 interrupt clear |
| wr_data | input | DATA_W | Write data |
| osc_tick | input | 1 | Clock-enable pulse from the internal oscillator domain |
| dbg_halt | input | 1 | Debug halt request |
| irq_o | output | 1 | Registered interrupt flag |
| rst_req_o | output | 1 | Registered, sticky reset request |
| count_o | output | CNT_W | Current counter value |

## Verification
The counting function is driven with three tick patterns: a tick on every cycle, tick pulses from the oscillator input, and ticks held off by a debug halt with freezing enabled and then disabled. Comparing these tells a wrong tick source apart from a broken freeze. Service traffic is tried as a correct key pair, a foreign value, the keys reversed, the first key repeated, and a correct pair sent early and then late in windowed mode. This separates a bad key check from a bad window compare. Each of the three fault responses is taken through one and two successive faults, with and without an interrupt clear in between. Rewrites of locked registers are shown to be ignored because counting and the reload value stay as first configured.

// File: rtl/wdt_window_pkg.sv
package wdt_window_pkg;

  localparam int ADDR_W = 3;
  localparam int KEY_W  = 16;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_WIN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SVC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ICLR = 3'd4;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA602;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hB480;

  typedef enum logic [1:0] {
    RSP_RST     = 2'b00,
    RSP_IRQ     = 2'b01,
    RSP_IRQ_RST = 2'b10,
    RSP_RST_ALT = 2'b11
  } wdt_rsp_e;

  // packed: tick_src is bit 5, en is bit 0
  typedef struct packed {
    logic     tick_src;
    logic     dbg_frz;
    wdt_rsp_e rsp;
    logic     win_mode;
    logic     en;
  } wdt_cfg_t;

  localparam int CFG_W = $bits(wdt_cfg_t);

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_window_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter bit EN_AT_RESET = 1'b0,
  parameter int RST_TIMEOUT = 1000,
  parameter int RST_WINDOW  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdt_cfg_t          cfg_q,
  output logic [CNT_W-1:0]  tmo_q,
  output logic [CNT_W-1:0]  win_q
);

  logic cfg_lock_q, tmo_lock_q, win_lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '{tick_src: 1'b0, dbg_frz: 1'b0, rsp: RSP_RST,
                      win_mode: 1'b0, en: EN_AT_RESET};
      tmo_q      <= CNT_W'(RST_TIMEOUT);
      win_q      <= CNT_W'(RST_WINDOW);
      cfg_lock_q <= 1'b0;
      tmo_lock_q <= 1'b0;
      win_lock_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG: if (!cfg_lock_q) begin
          cfg_q      <= wdt_cfg_t'({wr_data[CFG_W-1:1], wr_data[0] | cfg_q.en});
          cfg_lock_q <= 1'b1;
        end
        A_TMO: if (!tmo_lock_q) begin
          tmo_q      <= wr_data[CNT_W-1:0];
          tmo_lock_q <= 1'b1;
        end
        A_WIN: if (!win_lock_q) begin
          win_q      <= wr_data[CNT_W-1:0];
          win_lock_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wdt_svc_check.sv
module wdt_svc_check
  import wdt_window_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              win_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  win,
  output logic              svc_ok,
  output logic              svc_bad
);

  logic armed_q;
  logic key_wr, first_ok, done, too_early;

  always_comb begin
    key_wr    = en && wr_en && (wr_addr == A_SVC);
    first_ok  = key_wr && !armed_q && (wr_data[KEY_W-1:0] == KEY_FIRST);
    done      = key_wr && armed_q && (wr_data[KEY_W-1:0] == KEY_SECOND);
    too_early = win_mode && (cnt > win);
    svc_ok    = done && !too_early;
    svc_bad   = (key_wr && !first_ok && !done) || (done && too_early);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) armed_q <= 1'b0;
    else if (key_wr) armed_q <= first_ok;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W       = 16,
  parameter int RST_TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stop,
  input  logic             tick_src,
  input  logic             osc_tick,
  input  logic             dbg_frz,
  input  logic             dbg_halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  logic tick, active;

  always_comb begin
    tick   = tick_src ? osc_tick : 1'b1;
    active = en && !stop && tick && !(dbg_frz && dbg_halt);
    expire = active && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= CNT_W'(RST_TIMEOUT);
    else if (!en)                   cnt_q <= tmo;
    else if (reload)                cnt_q <= tmo;
    else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_window_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fault,
  input  wdt_rsp_e rsp,
  input  logic     irq_clr,
  output logic     irq_q,
  output logic     rst_q,
  output logic     irq_reload
);

  logic irq_kind;

  always_comb begin
    irq_kind   = (rsp == RSP_IRQ) || ((rsp == RSP_IRQ_RST) && !irq_q);
    irq_reload = fault && irq_kind;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (fault && !irq_kind) rst_q <= 1'b1;
      if (fault && irq_kind)  irq_q <= 1'b1;
      else if (irq_clr)       irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_window_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter bit EN_AT_RESET = 1'b0,
  parameter int RST_TIMEOUT = 1000,
  parameter int RST_WINDOW  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              osc_tick,
  input  logic              dbg_halt,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic [CNT_W-1:0]  count_o
);

  wdt_cfg_t         cfg_w;
  logic [CNT_W-1:0] tmo_w, win_w, cnt_w;
  logic             svc_ok, svc_bad, expire, fault, irq_reload, irq_clr;

  wdt_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .EN_AT_RESET(EN_AT_RESET),
    .RST_TIMEOUT(RST_TIMEOUT), .RST_WINDOW(RST_WINDOW)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_q(cfg_w), .tmo_q(tmo_w), .win_q(win_w)
  );

  wdt_svc_check #(.CNT_W(CNT_W), .DATA_W(DATA_W)) svc_i (
    .clk(clk), .rst(rst), .en(cfg_w.en), .win_mode(cfg_w.win_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt(cnt_w), .win(win_w), .svc_ok(svc_ok), .svc_bad(svc_bad)
  );

  assign fault   = svc_bad || (expire && !svc_ok);
  assign irq_clr = wr_en && (wr_addr == A_ICLR) && wr_data[0];

  wdt_counter #(.CNT_W(CNT_W), .RST_TIMEOUT(RST_TIMEOUT)) cnt_i (
    .clk(clk), .rst(rst), .en(cfg_w.en), .stop(rst_req_o),
    .tick_src(cfg_w.tick_src), .osc_tick(osc_tick),
    .dbg_frz(cfg_w.dbg_frz), .dbg_halt(dbg_halt),
    .reload(svc_ok || irq_reload), .tmo(tmo_w),
    .cnt_q(cnt_w), .expire(expire)
  );

  wdt_resp resp_i (
    .clk(clk), .rst(rst), .fault(fault), .rsp(cfg_w.rsp), .irq_clr(irq_clr),
    .irq_q(irq_o), .rst_q(rst_req_o), .irq_reload(irq_reload)
  );

  assign count_o = cnt_w;

endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
  import wdt_window_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       rsp,
  input logic             dbg_frz,
  input logic             dbg_halt,
  input logic             wr_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tmo,
  input logic             irq,
  input logic             rst_req
);

  // R9
  rst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && cnt != $past(cnt)) |->
      (cnt == CNT_W'($past(cnt) - 1'b1) || cnt == tmo));

  // R11
  frz_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && dbg_frz && dbg_halt && !wr_en) |=> $stable(cnt));

  // R9
  irq_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> ($past(rsp) != RSP_IRQ));

  // R10
  irq_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_req) && $past(rsp) == RSP_IRQ_RST) |-> $past(irq));

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!irq && !rst_req));

endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .en(cfg_w.en), .rsp(cfg_w.rsp),
  .dbg_frz(cfg_w.dbg_frz), .dbg_halt(dbg_halt), .wr_en(wr_en),
  .cnt(cnt_w), .tmo(tmo_w), .irq(irq_o), .rst_req(rst_req_o)
);

// File: tb/wdt_window_top_tb_top.sv
`timescale 1ns/1ps
module wdt_window_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        osc_tick = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        irq, rst_req, irq_on, rst_req_on;
  logic [15:0] cnt, cnt_on;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wdt_window_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_tick(osc_tick), .dbg_halt(dbg_halt),
    .irq_o(irq), .rst_req_o(rst_req), .count_o(cnt)
  );

  wdt_window_top #(.EN_AT_RESET(1'b1)) dut_on_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_tick(osc_tick), .dbg_halt(dbg_halt),
    .irq_o(irq_on), .rst_req_o(rst_req_on), .count_o(cnt_on)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgw(input bit en, input bit win, input logic [1:0] rsp,
                                       input bit frz, input bit src);
    return {10'd0, src, frz, rsp, win, en};
  endfunction

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; dbg_halt = 1'b0; osc_tick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic service();
    wr(3'd3, 16'hA602);
    wr(3'd3, 16'hB480);
  endtask

  task automatic tick1();
    @(posedge clk); #1;
  endtask

  task automatic wait_zero();
    for (int g = 0; g < 100000 && cnt != 0; g++) tick1();
  endtask

  task automatic t_reset();
    logic [15:0] a;
    do_reset();
    tick1();
    chk(irq == 0 && rst_req == 0, "R1 outputs low after reset", {irq, rst_req}, 0);
    chk(cnt == 1000, "R1 reset count", cnt, 1000);
    a = cnt_on;
    repeat (3) tick1();
    chk(a - cnt_on == 3, "R1 enabled-at-reset instance counts", a - cnt_on, 3);
    chk(cnt == 1000, "R2 disabled count holds", cnt, 1000);
    wr(3'd3, 16'h1234);
    tick1();
    chk(irq == 0 && rst_req == 0, "R2 bad key ignored while disabled", {irq, rst_req}, 0);
  endtask

  task automatic t_timeout_reset();
    logic [15:0] a;
    do_reset();
    wr(3'd1, 16'd20);
    wr(3'd0, cfgw(1, 0, 2'b00, 0, 0));
    a = cnt; tick1();
    chk(cnt == a - 1, "R3 one step per clock", cnt, a - 1);
    wait_zero();
    chk(rst_req == 0, "R8 no fault while count reaches zero", rst_req, 0);
    tick1();
    chk(rst_req == 1 && irq == 0, "R8 R9 timeout gives reset request", {rst_req, irq}, 2);
    repeat (3) tick1();
    chk(rst_req == 1, "R9 reset request sticky", rst_req, 1);
  endtask

  task automatic t_lock_service();
    logic [15:0] a;
    do_reset();
    wr(3'd1, 16'd30);
    wr(3'd0, cfgw(1, 0, 2'b01, 0, 0));
    wr(3'd1, 16'd5);
    wr(3'd0, cfgw(1, 0, 2'b00, 0, 1));
    a = cnt; tick1();
    chk(cnt == a - 1, "R4 config rewrite ignored, still counting per clock", cnt, a - 1);
    service();
    chk(cnt == 30, "R5 R4 service reloads first timeout", cnt, 30);
    chk(irq == 0, "R5 valid service no fault", irq, 0);
    wait_zero(); tick1();
    chk(irq == 1 && rst_req == 0 && cnt == 30, "R9 irq response reloads",
        {irq, rst_req, cnt}, {1'b1, 1'b0, 16'd30});
    wr(3'd4, 16'd1);
    chk(irq == 0, "R10 interrupt clear", irq, 0);
  endtask

  task automatic t_bad_keys();
    do_reset();
    wr(3'd1, 16'd100);
    wr(3'd0, cfgw(1, 0, 2'b01, 0, 0));
    wr(3'd3, 16'h1234);
    chk(irq == 1 && cnt == 100, "R6 foreign key faults", {irq, cnt}, {1'b1, 16'd100});
    wr(3'd4, 16'd1);
    wr(3'd3, 16'hB480);
    chk(irq == 1, "R6 second key alone faults", irq, 1);
    wr(3'd4, 16'd1);
    wr(3'd3, 16'hA602);
    wr(3'd3, 16'hA602);
    chk(irq == 1, "R6 repeated first key faults", irq, 1);
    wr(3'd4, 16'd1);
    service();
    chk(irq == 0 && cnt == 100, "R5 good pair after bad ones", {irq, cnt}, {1'b0, 16'd100});
  endtask

  task automatic t_window();
    do_reset();
    wr(3'd1, 16'd40);
    wr(3'd2, 16'd10);
    wr(3'd0, cfgw(1, 1, 2'b01, 0, 0));
    service();
    chk(irq == 1 && cnt == 40, "R7 early service faults", {irq, cnt}, {1'b1, 16'd40});
    wr(3'd4, 16'd1);
    for (int g = 0; g < 1000 && cnt > 10; g++) tick1();
    service();
    chk(irq == 0 && cnt == 40, "R7 service inside window", {irq, cnt}, {1'b0, 16'd40});
  endtask

  task automatic t_irq_then_reset();
    do_reset();
    wr(3'd1, 16'd8);
    wr(3'd0, cfgw(1, 0, 2'b10, 0, 0));
    wait_zero(); tick1();
    chk(irq == 1 && rst_req == 0 && cnt == 8, "R10 first timeout interrupt",
        {irq, rst_req, cnt}, {1'b1, 1'b0, 16'd8});
    wait_zero(); tick1();
    chk(rst_req == 1, "R10 second timeout resets", rst_req, 1);
    do_reset();
    wr(3'd1, 16'd8);
    wr(3'd0, cfgw(1, 0, 2'b10, 0, 0));
    wait_zero(); tick1();
    wr(3'd4, 16'd1);
    wait_zero(); tick1();
    chk(irq == 1 && rst_req == 0, "R10 cleared flag gives interrupt again",
        {irq, rst_req}, 2);
  endtask

  task automatic t_freeze();
    logic [15:0] a;
    do_reset();
    wr(3'd1, 16'd50);
    wr(3'd0, cfgw(1, 0, 2'b01, 1, 0));
    @(negedge clk) dbg_halt = 1'b1;
    tick1(); a = cnt;
    repeat (5) tick1();
    chk(cnt == a, "R11 frozen under debug halt", cnt, a);
    @(negedge clk) dbg_halt = 1'b0;
    tick1();
    chk(cnt == a - 1, "R11 resumes after halt", cnt, a - 1);
    do_reset();
    wr(3'd1, 16'd50);
    wr(3'd0, cfgw(1, 0, 2'b01, 0, 0));
    @(negedge clk) dbg_halt = 1'b1;
    tick1(); a = cnt;
    repeat (4) tick1();
    chk(cnt == a - 4, "R11 halt ignored without freeze", cnt, a - 4);
    dbg_halt = 1'b0;
  endtask

  task automatic t_osc();
    logic [15:0] a;
    do_reset();
    wr(3'd1, 16'd50);
    wr(3'd0, cfgw(1, 0, 2'b01, 0, 1));
    a = cnt;
    repeat (4) tick1();
    chk(cnt == a, "R3 oscillator source holds without pulses", cnt, a);
    @(negedge clk) osc_tick = 1'b1;
    tick1(); osc_tick = 1'b0;
    chk(cnt == a - 1, "R3 one step per oscillator pulse", cnt, a - 1);
  endtask

  initial begin
    t_reset();
    t_timeout_reset();
    t_lock_service();
    t_bad_keys();
    t_window();
    t_irq_then_reset();
    t_freeze();
    t_osc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule